// File: doc/BRIEF.md
# AXI Same-ID Ordering Gate

This block sits between one master and the slaves of an AXI interconnect on a single direction (read or write address path plus its completion path). Every request is passed straight through to the downstream address channel unless an older request carrying the same transaction ID is still waiting for its completion and the new request would be unsafe to overtake or run beside it. In that case the request is held, with both its ready and the downstream valid low, until the older completions have returned. The ID seen here already includes any bits that name the master, so the rules apply to each master on its own.

The destination slave is taken from the top address bits. The memory type comes from the upper three cache attribute bits: all zero means Device, anything else means Normal. Each ID has one table entry. The entry holds the number of outstanding requests, the slave they went to, and the byte range of the most recent request. Completions from the slaves are merged onto one master-side completion channel by fixed priority. A completion accepted by the master retires one outstanding request of its ID.

Top module: `axi_order_gate`

## Requirements
- R1: After reset the master completion valid and every slave completion ready are low, and the first request of any ID is accepted as soon as the downstream ready is high.
- R2: An accepted request appears on the downstream channel in the same cycle with ID, address, length, size and cache unchanged, and with the slave select equal to address bits [ADDR_W-1 -: SLV_W] (bits 15:14 by default).
- R3: A request whose ID has no outstanding request is never held, whatever the other IDs are doing.
- R4: A request whose ID has outstanding requests at a different slave is held until that ID's outstanding count is zero.
- R5: A Normal request (cache[3:1] not 000) whose ID has outstanding requests is held until the count is zero when its byte range overlaps the last accepted same-ID range. A range runs from the start address to start + (len+1)*2^size - 1.
- R6: A Device request (cache[3:1] = 000) to the same slave as its ID's outstanding requests is accepted even when its range overlaps the last one.
- R7: A Normal request to the same slave whose range does not overlap the last same-ID range is accepted.
- R8: At most MAX_OUT (8) requests per ID are outstanding. A further request of that ID is held until one of its completions is accepted.
- R9: When several slaves offer completions, the lowest-numbered one is forwarded with its ID and code unchanged. Only that slave sees ready, and only while the master ready is high.
- R10: A completion accepted by the master lowers its ID's count by one, so a held request is released in the cycle after the completion that clears its hazard.
- R11: While a request is held, req_ready_o and dn_valid_o are both low. req_ready_o is never high while dn_ready_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Master request valid |
| req_ready_o | output | 1 | Master request ready |
| req_id_i | input | ID_W | Request ID |
| req_addr_i | input | ADDR_W | Request start address |
| req_len_i | input | 8 | Burst length minus one |
| req_size_i | input | 3 | Log2 of bytes per beat |
| req_cache_i | input | 4 | Cache attributes |
| dn_valid_o | output | 1 | Downstream request valid |
| dn_ready_i | input | 1 | Downstream request ready |
| dn_id_o | output | ID_W | Downstream ID |
| dn_addr_o | output | ADDR_W | Downstream address |
| dn_len_o | output | 8 | Downstream length |
| dn_size_o | output | 3 | Downstream size |
| dn_cache_o | output | 4 | Downstream cache attributes |
| dn_slave_o | output | SLV_W | Decoded slave select |
| sl_rsp_valid_i | input | 2^SLV_W | Per-slave completion valid |
| sl_rsp_id_i | input | 2^SLV_W*ID_W | Per-slave completion ID, slave s at [s*ID_W +: ID_W] |
| sl_rsp_code_i | input | 2^SLV_W*RSP_W | Per-slave completion code |
| sl_rsp_ready_o | output | 2^SLV_W | Per-slave completion ready |
| m_rsp_valid_o | output | 1 | Master completion valid |
| m_rsp_ready_i | input | 1 | Master completion ready |
| m_rsp_id_o | output | ID_W | Master completion ID |
| m_rsp_code_o | output | RSP_W | Master completion code |

## Verification
The assertions assume the environment only returns a completion for an ID that has requests outstanding. They also assume each slave answers its own ID's requests in arrival order. The bench meets both by building its slave replies from a running model of what it has issued, and by sending completions for an ID only from the slave that ID was last routed to. Requests are held steady on the master side until they are accepted, so a held request stays visible until its hazard clears.

// File: rtl/order_pkg.sv
package order_pkg;
  localparam int LEN_W   = 8;
  localparam int SIZE_W  = 3;
  localparam int CACHE_W = 4;
  // (len+1) up to 256, shifted by up to 7
  localparam int BYTES_W = 16;

  function automatic logic [BYTES_W-1:0] burst_bytes(logic [LEN_W-1:0] len,
                                                     logic [SIZE_W-1:0] size);
    return (BYTES_W'(len) + BYTES_W'(1)) << size;
  endfunction

  function automatic logic is_device(logic [2:0] attr_hi);
    return attr_hi == 3'b000;
  endfunction
endpackage

// File: rtl/order_region_decode.sv
module order_region_decode
  import order_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SLV_W  = 2,
  parameter int END_W  = 17
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [SIZE_W-1:0]  size_i,
  input  logic [2:0]         attr_hi_i,
  output logic [SLV_W-1:0]   slave_o,
  output logic [END_W-1:0]   start_o,
  output logic [END_W-1:0]   end_o,
  output logic               dev_o
);
  logic [BYTES_W-1:0] bytes;

  assign bytes   = burst_bytes(len_i, size_i);
  assign slave_o = addr_i[ADDR_W-1 -: SLV_W];
  assign start_o = END_W'(addr_i);
  // widened by one bit so the last byte never wraps
  assign end_o   = END_W'(addr_i) + END_W'(bytes) - END_W'(1);
  assign dev_o   = is_device(attr_hi_i);
endmodule

// File: rtl/order_id_table.sv
module order_id_table #(
  parameter int ID_W    = 2,
  parameter int SLV_W   = 2,
  parameter int END_W   = 17,
  parameter int MAX_OUT = 8,
  localparam int N_ID   = 1 << ID_W,
  localparam int CNT_W  = $clog2(MAX_OUT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ID_W-1:0]  req_id_i,
  input  logic [SLV_W-1:0] req_slave_i,
  input  logic [END_W-1:0] req_start_i,
  input  logic [END_W-1:0] req_end_i,
  input  logic             req_dev_i,
  input  logic             req_fire_i,
  input  logic [ID_W-1:0]  rsp_id_i,
  input  logic             rsp_fire_i,
  output logic             hold_o
);
  logic [CNT_W-1:0] cnt_q   [N_ID];
  logic [SLV_W-1:0] slv_q   [N_ID];
  logic [END_W-1:0] start_q [N_ID];
  logic [END_W-1:0] end_q   [N_ID];

  for (genvar i = 0; i < N_ID; i++) begin : g_ent
    logic inc, dec;
    assign inc = req_fire_i && (req_id_i == ID_W'(i));
    assign dec = rsp_fire_i && (rsp_id_i == ID_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_q[i]   <= '0;
        slv_q[i]   <= '0;
        start_q[i] <= '0;
        end_q[i]   <= '0;
      end else begin
        case ({inc, dec})
          2'b10:   cnt_q[i] <= cnt_q[i] + CNT_W'(1);
          2'b01:   cnt_q[i] <= cnt_q[i] - CNT_W'(1);
          default: cnt_q[i] <= cnt_q[i];
        endcase
        if (inc) begin
          slv_q[i]   <= req_slave_i;
          start_q[i] <= req_start_i;
          end_q[i]   <= req_end_i;
        end
      end
    end
  end

  logic busy, full, other_slv, overlap;

  always_comb begin
    busy      = cnt_q[req_id_i] != '0;
    full      = cnt_q[req_id_i] == CNT_W'(MAX_OUT);
    other_slv = slv_q[req_id_i] != req_slave_i;
    overlap   = (req_start_i <= end_q[req_id_i]) && (start_q[req_id_i] <= req_end_i);
    // Device to the same slave rides the in-order path; Normal overlap waits
    hold_o    = busy && (full || other_slv || (!req_dev_i && overlap));
  end
endmodule

// File: rtl/order_rsp_mux.sv
module order_rsp_mux #(
  parameter int SLV_W = 2,
  parameter int ID_W  = 2,
  parameter int RSP_W = 2,
  localparam int N_SLV = 1 << SLV_W
) (
  input  logic [N_SLV-1:0]       sl_valid_i,
  input  logic [N_SLV*ID_W-1:0]  sl_id_i,
  input  logic [N_SLV*RSP_W-1:0] sl_code_i,
  output logic [N_SLV-1:0]       sl_ready_o,
  output logic                   m_valid_o,
  input  logic                   m_ready_i,
  output logic [ID_W-1:0]        m_id_o,
  output logic [RSP_W-1:0]       m_code_o
);
  logic [SLV_W-1:0] sel;

  always_comb begin
    sel       = '0;
    m_valid_o = 1'b0;
    // scan downwards so the lowest index wins
    for (int s = N_SLV - 1; s >= 0; s--) begin
      if (sl_valid_i[s]) begin
        sel       = SLV_W'(s);
        m_valid_o = 1'b1;
      end
    end
    m_id_o     = sl_id_i[sel*ID_W +: ID_W];
    m_code_o   = sl_code_i[sel*RSP_W +: RSP_W];
    sl_ready_o = (m_valid_o && m_ready_i) ? (N_SLV'(1) << sel) : '0;
  end
endmodule

// File: rtl/axi_order_gate.sv
module axi_order_gate
  import order_pkg::*;
#(
  parameter int ID_W    = 2,
  parameter int ADDR_W  = 16,
  parameter int SLV_W   = 2,
  parameter int MAX_OUT = 8,
  parameter int RSP_W   = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic [ID_W-1:0]               req_id_i,
  input  logic [ADDR_W-1:0]             req_addr_i,
  input  logic [7:0]                    req_len_i,
  input  logic [2:0]                    req_size_i,
  input  logic [3:0]                    req_cache_i,
  output logic                          dn_valid_o,
  input  logic                          dn_ready_i,
  output logic [ID_W-1:0]               dn_id_o,
  output logic [ADDR_W-1:0]             dn_addr_o,
  output logic [7:0]                    dn_len_o,
  output logic [2:0]                    dn_size_o,
  output logic [3:0]                    dn_cache_o,
  output logic [SLV_W-1:0]              dn_slave_o,
  input  logic [(1<<SLV_W)-1:0]         sl_rsp_valid_i,
  input  logic [(1<<SLV_W)*ID_W-1:0]    sl_rsp_id_i,
  input  logic [(1<<SLV_W)*RSP_W-1:0]   sl_rsp_code_i,
  output logic [(1<<SLV_W)-1:0]         sl_rsp_ready_o,
  output logic                          m_rsp_valid_o,
  input  logic                          m_rsp_ready_i,
  output logic [ID_W-1:0]               m_rsp_id_o,
  output logic [RSP_W-1:0]              m_rsp_code_o
);
  localparam int END_W = ((ADDR_W > BYTES_W) ? ADDR_W : BYTES_W) + 1;

  logic [SLV_W-1:0] slave;
  logic [END_W-1:0] rng_start, rng_end;
  logic             dev, hold, req_fire, rsp_fire;

  order_region_decode #(
    .ADDR_W(ADDR_W), .SLV_W(SLV_W), .END_W(END_W)
  ) u_decode (
    .addr_i   (req_addr_i),
    .len_i    (req_len_i),
    .size_i   (req_size_i),
    .attr_hi_i(req_cache_i[3:1]),
    .slave_o  (slave),
    .start_o  (rng_start),
    .end_o    (rng_end),
    .dev_o    (dev)
  );

  order_id_table #(
    .ID_W(ID_W), .SLV_W(SLV_W), .END_W(END_W), .MAX_OUT(MAX_OUT)
  ) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_id_i   (req_id_i),
    .req_slave_i(slave),
    .req_start_i(rng_start),
    .req_end_i  (rng_end),
    .req_dev_i  (dev),
    .req_fire_i (req_fire),
    .rsp_id_i   (m_rsp_id_o),
    .rsp_fire_i (rsp_fire),
    .hold_o     (hold)
  );

  order_rsp_mux #(
    .SLV_W(SLV_W), .ID_W(ID_W), .RSP_W(RSP_W)
  ) u_rsp (
    .sl_valid_i(sl_rsp_valid_i),
    .sl_id_i   (sl_rsp_id_i),
    .sl_code_i (sl_rsp_code_i),
    .sl_ready_o(sl_rsp_ready_o),
    .m_valid_o (m_rsp_valid_o),
    .m_ready_i (m_rsp_ready_i),
    .m_id_o    (m_rsp_id_o),
    .m_code_o  (m_rsp_code_o)
  );

  assign req_ready_o = dn_ready_i && !hold;
  assign dn_valid_o  = req_valid_i && !hold;
  assign req_fire    = req_valid_i && req_ready_o;
  assign rsp_fire    = m_rsp_valid_o && m_rsp_ready_i;

  assign dn_id_o    = req_id_i;
  assign dn_addr_o  = req_addr_i;
  assign dn_len_o   = req_len_i;
  assign dn_size_o  = req_size_i;
  assign dn_cache_o = req_cache_i;
  assign dn_slave_o = slave;
endmodule

// File: rtl/axi_order_gate_chk.sv
module axi_order_gate_chk #(
  parameter int ID_W    = 2,
  parameter int SLV_W   = 2,
  parameter int MAX_OUT = 8,
  localparam int N_ID   = 1 << ID_W,
  localparam int N_SLV  = 1 << SLV_W,
  localparam int CNT_W  = $clog2(MAX_OUT + 1) + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             req_ready_o,
  input logic             dn_valid_o,
  input logic             dn_ready_i,
  input logic [ID_W-1:0]  dn_id_o,
  input logic [SLV_W-1:0] dn_slave_o,
  input logic [N_SLV-1:0] sl_rsp_valid_i,
  input logic [N_SLV-1:0] sl_rsp_ready_o,
  input logic             m_rsp_valid_o,
  input logic             m_rsp_ready_i,
  input logic [ID_W-1:0]  m_rsp_id_o
);
  // R11
  ready_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> dn_ready_i);

  // R9
  grant_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sl_rsp_ready_o));

  // R9
  grant_when_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sl_rsp_ready_o != '0) |-> (m_rsp_valid_o && m_rsp_ready_i));

  // R9
  valid_has_source_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    m_rsp_valid_o |-> (sl_rsp_valid_i != '0));

  for (genvar i = 0; i < N_ID; i++) begin : g_id
    logic [CNT_W-1:0] cnt_s;
    logic [SLV_W-1:0] slv_s;
    logic inc, dec;
    assign inc = dn_valid_o && dn_ready_i && (dn_id_o == ID_W'(i));
    assign dec = m_rsp_valid_o && m_rsp_ready_i && (m_rsp_id_o == ID_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cnt_s <= '0;
        slv_s <= '0;
      end else begin
        cnt_s <= cnt_s + CNT_W'(inc) - CNT_W'(dec);
        if (inc) slv_s <= dn_slave_o;
      end
    end

    // R8
    id_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cnt_s <= CNT_W'(MAX_OUT));

    // R4
    same_slave_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (inc && cnt_s != '0) |-> (dn_slave_o == slv_s));

    // R10
    retire_outstanding_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dec |-> (cnt_s != '0));
  end
endmodule

bind axi_order_gate axi_order_gate_chk #(
  .ID_W(ID_W), .SLV_W(SLV_W), .MAX_OUT(MAX_OUT)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_ready_o   (req_ready_o),
  .dn_valid_o    (dn_valid_o),
  .dn_ready_i    (dn_ready_i),
  .dn_id_o       (dn_id_o),
  .dn_slave_o    (dn_slave_o),
  .sl_rsp_valid_i(sl_rsp_valid_i),
  .sl_rsp_ready_o(sl_rsp_ready_o),
  .m_rsp_valid_o (m_rsp_valid_o),
  .m_rsp_ready_i (m_rsp_ready_i),
  .m_rsp_id_o    (m_rsp_id_o)
);

// File: tb/axi_order_gate_tb.sv
module axi_order_gate_tb;
  localparam int ID_W = 2, ADDR_W = 16, SLV_W = 2, RSP_W = 2, MAX_OUT = 8;
  localparam int N_SLV = 1 << SLV_W;
  localparam int DN_W = ID_W + ADDR_W + 8 + 3 + 4 + SLV_W;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 1'b0, req_ready;
  logic [ID_W-1:0] req_id = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic [2:0] req_size = '0;
  logic [3:0] req_cache = '0;
  logic dn_valid, dn_ready = 1'b1;
  logic [ID_W-1:0] dn_id;
  logic [ADDR_W-1:0] dn_addr;
  logic [7:0] dn_len;
  logic [2:0] dn_size;
  logic [3:0] dn_cache;
  logic [SLV_W-1:0] dn_slave;
  logic [N_SLV-1:0] sl_valid = '0, sl_ready;
  logic [N_SLV*ID_W-1:0] sl_id = '0;
  logic [N_SLV*RSP_W-1:0] sl_code = '0;
  logic m_valid, m_ready = 1'b1;
  logic [ID_W-1:0] m_id;
  logic [RSP_W-1:0] m_code;

  axi_order_gate #(.ID_W(ID_W), .ADDR_W(ADDR_W), .SLV_W(SLV_W),
                   .MAX_OUT(MAX_OUT), .RSP_W(RSP_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_id_i(req_id),
    .req_addr_i(req_addr), .req_len_i(req_len), .req_size_i(req_size),
    .req_cache_i(req_cache),
    .dn_valid_o(dn_valid), .dn_ready_i(dn_ready), .dn_id_o(dn_id),
    .dn_addr_o(dn_addr), .dn_len_o(dn_len), .dn_size_o(dn_size),
    .dn_cache_o(dn_cache), .dn_slave_o(dn_slave),
    .sl_rsp_valid_i(sl_valid), .sl_rsp_id_i(sl_id), .sl_rsp_code_i(sl_code),
    .sl_rsp_ready_o(sl_ready),
    .m_rsp_valid_o(m_valid), .m_rsp_ready_i(m_ready), .m_rsp_id_o(m_id),
    .m_rsp_code_o(m_code)
  );

  int n_chk = 0, n_fail = 0;
  logic [DN_W-1:0] dn_q[$];
  logic [ID_W+RSP_W-1:0] rsp_q[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // monitor: downstream requests (R2)
  always @(negedge clk) begin
    if (rst_n && dn_valid && dn_ready) begin
      logic [DN_W-1:0] act, exp;
      act = {dn_id, dn_addr, dn_len, dn_size, dn_cache, dn_slave};
      if (dn_q.size() == 0) chk(1'b0, "R2 unexpected request", 64'(act), 0);
      else begin
        exp = dn_q.pop_front();
        chk(act == exp, "R2 downstream request", 64'(act), 64'(exp));
      end
    end
  end

  // monitor: master completions (R9)
  always @(negedge clk) begin
    if (rst_n && m_valid && m_ready) begin
      logic [ID_W+RSP_W-1:0] act, exp;
      act = {m_id, m_code};
      if (rsp_q.size() == 0) chk(1'b0, "R9 unexpected completion", 64'(act), 0);
      else begin
        exp = rsp_q.pop_front();
        chk(act == exp, "R9 completion order", 64'(act), 64'(exp));
      end
    end
  end

  task automatic issue(input logic [ID_W-1:0] id, input logic [ADDR_W-1:0] addr,
                       input logic [7:0] len, input logic [2:0] size,
                       input logic [3:0] cache);
    @(posedge clk); #1;
    dn_q.push_back({id, addr, len, size, cache, addr[ADDR_W-1 -: SLV_W]});
    req_id = id; req_addr = addr; req_len = len; req_size = size;
    req_cache = cache; req_valid = 1'b1;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic held(input int n, input string req);
    @(posedge clk); #1;
    repeat (n) begin
      @(negedge clk);
      chk(!req_ready && !dn_valid, req, 64'({req_ready, dn_valid}), 0);
    end
  endtask

  task automatic send_rsp(input int slv, input logic [ID_W-1:0] id,
                          input logic [RSP_W-1:0] code);
    @(posedge clk); #1;
    rsp_q.push_back({id, code});
    sl_id[slv*ID_W +: ID_W] = id;
    sl_code[slv*RSP_W +: RSP_W] = code;
    sl_valid[slv] = 1'b1;
    @(negedge clk);
    while (!sl_ready[slv]) @(negedge clk);
    @(posedge clk); #1;
    sl_valid[slv] = 1'b0;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog act=hung exp=done");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk(!m_valid && sl_ready == '0, "R1 reset state", 64'({m_valid, sl_ready}), 0);

    // R1 R2: first request of id0, Normal, 0x100..0x10F, slave 0
    issue(2'd0, 16'h0100, 8'd3, 3'd2, 4'b0010);
    // R3: id1 Device to slave 1
    issue(2'd1, 16'h4000, 8'd0, 3'd2, 4'b0000);
    // R7: id0 Normal 0x200..0x20F, no overlap
    issue(2'd0, 16'h0200, 8'd3, 3'd2, 4'b0010);
    // R6: id0 Device overlapping 0x200..0x203, same slave
    issue(2'd0, 16'h0200, 8'd0, 3'd2, 4'b0000);
    chk(dn_q.size() == 0, "R6 R7 accepted", 64'(dn_q.size()), 0);

    // R5 R10: id0 Normal at 0x202 overlaps, held until three completions
    fork
      issue(2'd0, 16'h0202, 8'd0, 3'd0, 4'b0110);
      begin
        held(3, "R5 overlap held");
        send_rsp(0, 2'd0, 2'b00);
        held(1, "R5 held after one completion");
        send_rsp(0, 2'd0, 2'b00);
        held(1, "R5 held after two completions");
        send_rsp(0, 2'd0, 2'b00);
      end
    join
    chk(dn_q.size() == 0, "R10 release after last completion", 64'(dn_q.size()), 0);

    // R4: id0 to slave 2 while one is outstanding at slave 0
    fork
      issue(2'd0, 16'h8000, 8'd1, 3'd2, 4'b0010);
      begin
        held(3, "R4 other slave held");
        send_rsp(0, 2'd0, 2'b00);
      end
    join
    chk(dn_q.size() == 0, "R4 release", 64'(dn_q.size()), 0);

    // R9: slave 1 (id1) and slave 2 (id0) at once, lowest first
    @(posedge clk); #1;
    m_ready = 1'b0;
    sl_id[1*ID_W +: ID_W] = 2'd1; sl_code[1*RSP_W +: RSP_W] = 2'b01; sl_valid[1] = 1'b1;
    sl_id[2*ID_W +: ID_W] = 2'd0; sl_code[2*RSP_W +: RSP_W] = 2'b10; sl_valid[2] = 1'b1;
    rsp_q.push_back({2'd1, 2'b01});
    rsp_q.push_back({2'd0, 2'b10});
    @(negedge clk);
    chk(m_valid && m_id == 2'd1 && sl_ready == '0, "R9 backpressure",
        64'({m_valid, m_id, sl_ready}), 64'({1'b1, 2'd1, 4'b0000}));
    @(posedge clk); #1 m_ready = 1'b1;
    @(negedge clk);
    chk(sl_ready == 4'b0010, "R9 lowest slave granted", 64'(sl_ready), 64'h2);
    @(posedge clk); #1 sl_valid[1] = 1'b0;
    @(negedge clk);
    chk(sl_ready == 4'b0100, "R9 next slave granted", 64'(sl_ready), 64'h4);
    @(posedge clk); #1 sl_valid[2] = 1'b0;

    // R8: eight Device requests of id2 to slave 3
    for (int k = 0; k < MAX_OUT; k++)
      issue(2'd2, 16'hC000 + 16'(k * 16), 8'd0, 3'd2, 4'b0000);
    // R3: id3 unaffected by full id2
    issue(2'd3, 16'h0000, 8'd0, 3'd2, 4'b0010);
    chk(dn_q.size() == 0, "R8 R3 accepted", 64'(dn_q.size()), 0);
    fork
      issue(2'd2, 16'hC100, 8'd0, 3'd2, 4'b0000);
      begin
        held(3, "R8 limit held");
        send_rsp(3, 2'd2, 2'b00);
      end
    join
    chk(dn_q.size() == 0, "R8 release", 64'(dn_q.size()), 0);
    for (int k = 0; k < MAX_OUT; k++) send_rsp(3, 2'd2, 2'b11);
    send_rsp(0, 2'd3, 2'b00);

    repeat (3) @(negedge clk);
    chk(rsp_q.size() == 0, "R9 all completions forwarded", 64'(rsp_q.size()), 0);
    // R3: every ID idle again, fresh request passes
    issue(2'd0, 16'h4000, 8'd0, 3'd0, 4'b0010);
    chk(dn_q.size() == 0, "R3 idle accept", 64'(dn_q.size()), 0);
    finish_run();
  end
endmodule